// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Controller

A sixteen-line general-purpose I/O port controlled through a 16-bit register interface. Every line carries a direction bit: a line set as an output drives the stored output value on its pin, and a line set as an input is sampled through a two-stage synchroniser and watched for transitions. Each input line picks its own interrupt polarity (rising or falling) and has its own mask bit. Recorded events collect in a pending word that drives one interrupt line. Software clears the pending word by reading it, and only unmasked bits are cleared.

One pin, chosen by software, can also act as a capture trigger. When that pin makes a transition that is allowed to record an event, the whole synchronised input word is copied into a capture register. A debounce setting register is provided as plain storage. The register port uses single-cycle accesses. Read data is combinational from the current state, and the side effect of a read takes place at the clock edge that ends the access.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the direction word reads 0xFFFF (all inputs), and every other register reads 0. `pin_oe` and `irq` are 0.
- R2: Word index `bus_addr[5:2]` selects the register. Byte offsets: 0x00 synchronised input levels (read-only), 0x04 output value, 0x08 direction, 0x18 capture control, 0x1C polarity, 0x24 pending (read-only), 0x2C mask, 0x30 debounce, 0x34 captured word (read-only). Unmapped offsets read 0.
- R3: A direction bit of 0 makes the line an output. `pin_oe` is the inverse of the direction word. `pin_out` equals the output value ANDed with the inverted direction word, and it reflects a write to either register in the cycle after that write.
- R4: The input-level register shows `pin_in` after two clock edges of synchroniser latency.
- R5: A polarity bit of 1 records a rising transition and a bit of 0 records a falling transition. The pending bit is visible after the third rising clock edge following the pin change.
- R6: No event is recorded for a line that is an output, for a line whose mask bit is 1, or while `func_clk_en` is 0.
- R7: A read of the pending register returns its value. At the end of that access it clears the pending bits whose mask bit is 0, and it keeps the pending bits of masked lines.
- R8: If an event arrives in the same cycle as a clearing read of the pending register, the event's bit is set afterwards.
- R9: `irq` is the OR of the pending bits. It stays high until a read clears the pending bits.
- R10: The capture control register keeps its low 5 bits. Bit 0 enables capture, and bits 4:1 hold the trigger line index. While capture is enabled, any transition of the trigger line that passes the R6 gating copies the synchronised input word into the capture register.
- R11: The debounce register keeps only its low 9 bits.
- R12: Writes to offsets 0x00, 0x24 and 0x34 change no state.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_clk_en | input | 1 | Functional clock enable; events are recorded only while it is 1 |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin output enable |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt, OR of pending bits |

## Verification
The bench drives pins at exact cycle positions to test the synchroniser latency and the per-line polarity. A design with the polarity inverted would flag the opposite edges, and an extra pipeline stage would show the level one cycle late. The bench times a new edge to land in the same cycle as a clearing read. A design that ignores this case would lose that interrupt. The bench also reads a masked pending bit several times; a design that clears all bits on read would drop it. For capture, the bench holds the trigger pin steady while other pins change, then toggles capture off. A design that captures on any pin, or that ignores the enable bit, would overwrite the captured word.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    parameter int unsigned PIN_W       = 16;
    parameter int unsigned DEB_W       = 9;
    parameter int unsigned SYNC_STAGES = 2;
    parameter int unsigned ADDR_W      = 6;
    localparam int unsigned IDX_W      = $clog2(PIN_W);
    localparam int unsigned EVT_W      = IDX_W + 1;
    localparam int unsigned WIDX_W     = ADDR_W - 2;

    typedef enum logic [WIDX_W-1:0] {
        WI_LEVEL = 4'd0,
        WI_OUT   = 4'd1,
        WI_DIR   = 4'd2,
        WI_EVT   = 4'd6,
        WI_EDGE  = 4'd7,
        WI_PEND  = 4'd9,
        WI_MASK  = 4'd11,
        WI_DEB   = 4'd12,
        WI_CAP   = 4'd13
    } word_idx_e;

    typedef struct packed {
        logic [PIN_W-1:0] outv;
        logic [PIN_W-1:0] dir;
        logic [EVT_W-1:0] evt;
        logic [PIN_W-1:0] pol;
        logic [PIN_W-1:0] mask;
        logic [DEB_W-1:0] deb;
        logic [PIN_W-1:0] pend;
        logic [PIN_W-1:0] cap;
    } regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] gate, rise, fall;

    always_comb begin
        prev_d = lvl;
        gate   = dir & ~mask & {W{en}};
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
        hit    = gate & ((pol & rise) | (~pol & fall));
        chg    = gate & (rise | fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_clk_en,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic              irq
);
    regs_t r_d, r_q;
    logic [PIN_W-1:0]  lvl, hit, chg;
    logic [WIDX_W-1:0] widx;
    logic [IDX_W-1:0]  trig_pin;
    logic acc_wr, acc_rd, pend_rd;

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    gpio_edge_detect #(.W(PIN_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .en(func_clk_en), .lvl(lvl),
        .dir(r_q.dir), .mask(r_q.mask), .pol(r_q.pol),
        .hit(hit), .chg(chg)
    );

    always_comb begin
        widx     = bus_addr[ADDR_W-1:2];
        acc_wr   = bus_sel & bus_wr;
        acc_rd   = bus_sel & ~bus_wr;
        pend_rd  = acc_rd && (widx == WI_PEND);
        trig_pin = r_q.evt[EVT_W-1:1];
        r_d      = r_q;
        if (acc_wr) begin
            case (widx)
                WI_OUT:  r_d.outv = bus_wdata;
                WI_DIR:  r_d.dir  = bus_wdata;
                WI_EVT:  r_d.evt  = bus_wdata[EVT_W-1:0];
                WI_EDGE: r_d.pol  = bus_wdata;
                WI_MASK: r_d.mask = bus_wdata;
                WI_DEB:  r_d.deb  = bus_wdata[DEB_W-1:0];
                default: ;
            endcase
        end
        r_d.pend = (pend_rd ? (r_q.pend & r_q.mask) : r_q.pend) | hit;
        if (r_q.evt[0] && chg[trig_pin]) r_d.cap = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            case (widx)
                WI_LEVEL: bus_rdata = lvl;
                WI_OUT:   bus_rdata = r_q.outv;
                WI_DIR:   bus_rdata = r_q.dir;
                WI_EVT:   bus_rdata = PIN_W'(r_q.evt);
                WI_EDGE:  bus_rdata = r_q.pol;
                WI_PEND:  bus_rdata = r_q.pend;
                WI_MASK:  bus_rdata = r_q.mask;
                WI_DEB:   bus_rdata = PIN_W'(r_q.deb);
                WI_CAP:   bus_rdata = r_q.cap;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe  = ~r_q.dir;
    assign pin_out = r_q.outv & ~r_q.dir;
    assign irq     = |r_q.pend;

    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd |=> ((r_q.pend & ~$past(r_q.mask) & ~$past(hit)) == '0));
    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd |=> ((r_q.pend & $past(r_q.mask)) == ($past(r_q.pend) & $past(r_q.mask))));
    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((r_q.pend & $past(hit)) == $past(hit)));
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(pend_rd));
    // R6
    hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit | chg) & (~r_q.dir | r_q.mask)) == '0);
    // R6
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !func_clk_en |-> ((hit | chg) == '0));
    // R10
    evt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && widx == WI_EVT) |=> (r_q.evt == $past(bus_wdata[EVT_W-1:0])));
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_clk_en = 1'b1;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, bus_rdata;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    logic [15:0] rv;

    localparam logic [5:0] A_LVL = 6'h00, A_OUT = 6'h04, A_DIR = 6'h08, A_EVT = 6'h18,
        A_POL = 6'h1C, A_PEND = 6'h24, A_MASK = 6'h2C, A_DEB = 6'h30, A_CAP = 6'h34;

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .func_clk_en(func_clk_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic drive(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd(A_DIR, rv);  check("R1 dir", rv, 16'hFFFF);
        rd(A_OUT, rv);  check("R1 out", rv, 16'h0);
        rd(A_EVT, rv);  check("R1 evt", rv, 16'h0);
        rd(A_POL, rv);  check("R1 pol", rv, 16'h0);
        rd(A_MASK, rv); check("R1 mask", rv, 16'h0);
        rd(A_DEB, rv);  check("R1 deb", rv, 16'h0);
        rd(A_PEND, rv); check("R1 pend", rv, 16'h0);
        rd(A_CAP, rv);  check("R1 cap", rv, 16'h0);
        check("R1 oe", pin_oe, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
        rd(6'h3C, rv);  check("R2 unmapped", rv, 16'h0);
    endtask

    task automatic t_output;
        wr(A_DIR, 16'hFF00);
        wr(A_OUT, 16'h0F0F);
        check("R3 oe", pin_oe, 16'h00FF);
        check("R3 out", pin_out, 16'h000F);
        wr(A_DIR, 16'hF000);
        check("R3 out after dir", pin_out, 16'h0F0F);
        wr(A_DIR, 16'hFFFF);
        check("R3 out all in", pin_out, 16'h0000);
        rd(A_OUT, rv); check("R2 out readback", rv, 16'h0F0F);
    endtask

    task automatic t_input;
        @(negedge clk);
        pin_in = 16'h1234;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_LVL;
        #2 check("R4 one edge", bus_rdata, 16'h0000);
        @(negedge clk);
        #2 check("R4 two edges", bus_rdata, 16'h1234);
        bus_sel = 1'b0;
        drive(16'h0000);
        rd(A_PEND, rv); check("R5 falling default", rv, 16'h1234);
    endtask

    task automatic t_edges;
        wr(A_POL, 16'h00FF);
        drive(16'h0F0F);
        check("R9 irq set", {15'h0, irq}, 16'h1);
        repeat (5) @(negedge clk);
        check("R9 irq held", {15'h0, irq}, 16'h1);
        rd(A_PEND, rv); check("R5 rising", rv, 16'h000F);
        check("R9 irq cleared", {15'h0, irq}, 16'h0);
        drive(16'h0000);
        rd(A_PEND, rv); check("R5 falling", rv, 16'h0F00);
    endtask

    task automatic t_gate;
        wr(A_POL, 16'hFFFF);
        wr(A_DIR, 16'hFFFE);
        wr(A_MASK, 16'h0002);
        drive(16'h0003);
        @(negedge clk); func_clk_en = 1'b0;
        drive(16'h0007);
        rd(A_PEND, rv); check("R6 gated", rv, 16'h0000);
        check("R6 irq", {15'h0, irq}, 16'h0);
        func_clk_en = 1'b1;
        wr(A_DIR, 16'hFFFF);
        wr(A_MASK, 16'h0000);
        drive(16'h0000);
        rd(A_PEND, rv); check("R6 no rising on fall", rv, 16'h0000);
    endtask

    task automatic t_clear;
        drive(16'h0030);
        wr(A_MASK, 16'h0020);
        rd(A_PEND, rv); check("R7 first read", rv, 16'h0030);
        rd(A_PEND, rv); check("R7 masked kept", rv, 16'h0020);
        check("R9 irq masked pend", {15'h0, irq}, 16'h1);
        wr(A_MASK, 16'h0000);
        rd(A_PEND, rv); check("R7 still kept", rv, 16'h0020);
        rd(A_PEND, rv); check("R7 cleared", rv, 16'h0000);
        drive(16'h0000);
    endtask

    task automatic t_same;
        drive(16'h0001);
        drive(16'h0000);
        @(negedge clk);
        pin_in = 16'h0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_PEND;
        #2 rv = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R8 read value", rv, 16'h0001);
        rd(A_PEND, rv); check("R8 edge wins", rv, 16'h0001);
        rd(A_PEND, rv); check("R8 then clear", rv, 16'h0000);
        drive(16'h0000);
    endtask

    task automatic t_capture;
        wr(A_EVT, 16'hFFFF);
        rd(A_EVT, rv); check("R10 evt width", rv, 16'h001F);
        wr(A_EVT, 16'h0007);
        drive(16'h00A8);
        rd(A_CAP, rv); check("R10 capture rise", rv, 16'h00A8);
        drive(16'h00B8);
        rd(A_CAP, rv); check("R10 other pin", rv, 16'h00A8);
        drive(16'h00B0);
        rd(A_CAP, rv); check("R10 capture fall", rv, 16'h00B0);
        wr(A_EVT, 16'h0006);
        drive(16'h00B8);
        rd(A_CAP, rv); check("R10 disabled", rv, 16'h00B0);
        rd(A_PEND, rv);
    endtask

    task automatic t_misc;
        wr(A_DEB, 16'hFFFF);
        rd(A_DEB, rv); check("R11 deb width", rv, 16'h01FF);
        drive(16'h5A5A);
        rd(A_PEND, rv);
        wr(A_LVL, 16'h0000);
        wr(A_PEND, 16'hFFFF);
        wr(A_CAP, 16'hFFFF);
        rd(A_LVL, rv);  check("R12 level", rv, 16'h5A5A);
        rd(A_PEND, rv); check("R12 pend", rv, 16'h0000);
        rd(A_CAP, rv);  check("R12 cap", rv, 16'h00B0);
        check("R12 irq", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_output;
        t_input;
        t_edges;
        t_gate;
        t_clear;
        t_same;
        t_capture;
        t_misc;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule